// File: doc/BRIEF.md
# Pairable Six-Channel Pulse-Width Modulator

This block generates six pulse-width modulated outputs from a shared clock-enable tick. Each channel has an 8-bit period, an 8-bit duty value, a polarity bit, an enable bit and a choice between left-aligned (edge) and center-aligned (up/down) counting. Any adjacent pair of channels (0/1, 2/3, 4/5) can be fused into one channel with 16-bit period and duty, so the block runs as six narrow channels, three wide ones, or a mix of the two.

Software programs the block through a simple synchronous write port. Period, duty, polarity and alignment values are copied into working copies only when a period wraps or while the channel is off. A period that is running is therefore never cut short or stretched by a write. A fuse bit can change only while both channels of its pair are off.

Top module: `pwm_fusable`

## Requirements
- R1: After reset every output is low and every register reads as zero. Enabling a channel that has never been written gives a constant low output, because period 0 with polarity 0 selects the inactive level.
- R2: Left-aligned mode (align bit 0) with 0 < D < P repeats every P ticks. The output is high for D ticks when the polarity bit is 1 and for P−D ticks when it is 0.
- R3: Center-aligned mode (align bit 1) counts 0 up to P−1, then P down to 1. Its period is 2·P ticks, and the output is high for 2·D ticks (polarity 1) or 2·(P−D) ticks (polarity 0). For example, P=4, D=1 with polarity 0 gives 6 of 8 ticks high.
- R4: Register map on the 5-bit write address. Bits [4:3] select the group: 0 = period, 1 = duty, 2 = control. Bits [2:0] give the channel index for the period and duty groups. In the control group they select the register: 0 = enable, 1 = polarity, 2 = alignment, 3 = fuse. The first three are per-channel bit vectors with bit n for channel n. In the fuse register, bit k controls pair 2k/2k+1.
- R5: While fuse bit k is 1, the pair works as one channel with period {period[2k], period[2k+1]} and duty {duty[2k], duty[2k+1]}. The even channel supplies the high byte. The pair uses the enable, polarity and alignment bits of channel 2k+1 and drives its result on output 2k+1. Output 2k stays low.
- R6: A write to the fuse register changes bit k only when enable bits 2k and 2k+1 are both 0. Otherwise bit k keeps its old value.
- R7: New period, duty, polarity and alignment values take effect only at the next period wrap or while the channel is disabled. The period in progress when they are written finishes with the old values.
- R8: Period 0, or a duty value of at least the period, gives a constant output equal to the polarity bit. Duty 0 with a nonzero period gives a constant inverted polarity level.
- R9: Clearing a channel's enable bit drives its output low one clock after the write and restarts its count from zero.
- R10: Counters advance only on clocks where tick is 1. Running tick at every other clock doubles every output duration.
- R11: The channels run independently: settings on one channel do not change the waveform of another unfused channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address (see R4) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
A write is captured at the clock edge where wr_en is high. The output register then reflects the new count state one edge later. A cleared enable therefore shows a low output on the second falling edge after the write strobe is driven, and the bench checks it there. New period and duty values appear only after the current period wraps. The bench first waits three expected periods, then finds a rising edge of the output by sampling at falling clock edges, and measures whole high and low runs from it. The shadow test starts its writes right after a detected rising edge. It expects the next run to keep the old lengths and the run after that to show the new ones.

// File: rtl/pwm_fusable_pkg.sv
package pwm_fusable_pkg;

    localparam int ADDR_W = 5;

    // Register group selected by address bits [4:3].
    typedef enum logic [1:0] {
        GRP_PERIOD = 2'd0,
        GRP_DUTY   = 2'd1,
        GRP_CTRL   = 2'd2,
        GRP_NONE   = 2'd3
    } reg_grp_e;

    // Control register selected by address bits [2:0] within GRP_CTRL.
    localparam logic [2:0] CTL_ENABLE   = 3'd0;
    localparam logic [2:0] CTL_POLARITY = 3'd1;
    localparam logic [2:0] CTL_CENTER   = 3'd2;
    localparam logic [2:0] CTL_FUSE     = 3'd3;

endpackage

// File: rtl/pwm_fusable_regs.sv
module pwm_fusable_regs
    import pwm_fusable_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int DW    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DW-1:0]                      wr_data,
    output logic [2*NPAIR-1:0][DW-1:0]         per_o,
    output logic [2*NPAIR-1:0][DW-1:0]         duty_o,
    output logic [2*NPAIR-1:0]                 en_o,
    output logic [2*NPAIR-1:0]                 pol_o,
    output logic [2*NPAIR-1:0]                 ctr_o,
    output logic [NPAIR-1:0]                   fuse_o
);

    localparam int NCH = 2 * NPAIR;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] per;
        logic [NCH-1:0][DW-1:0] duty;
        logic [NCH-1:0]         en;
        logic [NCH-1:0]         pol;
        logic [NCH-1:0]         ctr;
        logic [NPAIR-1:0]       fuse;
    } regs_t;

    regs_t r_d, r_q;
    logic [2:0] idx;
    reg_grp_e   grp;

    always_comb begin
        r_d = r_q;
        idx = wr_addr[2:0];
        grp = reg_grp_e'(wr_addr[4:3]);
        if (wr_en) begin
            case (grp)
                GRP_PERIOD: if (int'(idx) < NCH) r_d.per[idx]  = wr_data;
                GRP_DUTY:   if (int'(idx) < NCH) r_d.duty[idx] = wr_data;
                GRP_CTRL: begin
                    case (idx)
                        CTL_ENABLE:   r_d.en  = wr_data[NCH-1:0];
                        CTL_POLARITY: r_d.pol = wr_data[NCH-1:0];
                        CTL_CENTER:   r_d.ctr = wr_data[NCH-1:0];
                        CTL_FUSE: begin
                            for (int p = 0; p < NPAIR; p++) begin
                                if (!(r_q.en[2*p] || r_q.en[2*p+1])) begin
                                    r_d.fuse[p] = wr_data[p];
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign per_o  = r_q.per;
    assign duty_o = r_q.duty;
    assign en_o   = r_q.en;
    assign pol_o  = r_q.pol;
    assign ctr_o  = r_q.ctr;
    assign fuse_o = r_q.fuse;

    for (genvar p = 0; p < NPAIR; p++) begin : g_lock
        AST_FUSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.en[2*p] || r_q.en[2*p+1]) |=> (r_q.fuse[p] == $past(r_q.fuse[p]))); // R6
    end

endmodule

// File: rtl/pwm_fusable_engine.sv
module pwm_fusable_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         pol,
    input  logic         ctr,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    output logic         out
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic [W-1:0] per_s;
        logic [W-1:0] duty_s;
        logic         pol_s;
        logic         ctr_s;
        logic         out;
    } eng_t;

    eng_t s_d, s_q;
    logic wrap, turn, full, active;

    always_comb begin
        s_d = s_q;
        // End of the current period for the working settings.
        if (s_q.per_s == '0) begin
            wrap = 1'b1;
        end else if (s_q.ctr_s) begin
            wrap = s_q.down && (s_q.cnt == W'(1));
        end else begin
            wrap = (s_q.cnt == s_q.per_s - W'(1));
        end
        turn = s_q.ctr_s && !s_q.down && (s_q.cnt == s_q.per_s - W'(1));

        if (!en || (tick && wrap)) begin
            s_d.cnt    = '0;
            s_d.down   = 1'b0;
            s_d.per_s  = per;
            s_d.duty_s = duty;
            s_d.pol_s  = pol;
            s_d.ctr_s  = ctr;
        end else if (tick) begin
            if (turn) begin
                s_d.down = 1'b1;
                s_d.cnt  = s_q.per_s;
            end else if (s_q.down) begin
                s_d.cnt  = s_q.cnt - W'(1);
            end else begin
                s_d.cnt  = s_q.cnt + W'(1);
            end
        end

        full   = (s_d.duty_s >= s_d.per_s);
        active = (s_d.ctr_s && s_d.down) ? (s_d.cnt <= s_d.duty_s)
                                         : (s_d.cnt <  s_d.duty_s);
        s_d.out = en && ((full || active) ? s_d.pol_s : !s_d.pol_s);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out = s_q.out;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.per_s != '0) |-> (s_q.ctr_s ? (s_q.cnt <= s_q.per_s) : (s_q.cnt < s_q.per_s))); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> ($stable(s_q.per_s) && $stable(s_q.duty_s) && $stable(s_q.pol_s))); // R7
    AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (s_q.duty_s >= s_q.per_s)) |-> (out == s_q.pol_s)); // R8
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out); // R9

endmodule

// File: rtl/pwm_fusable.sv
module pwm_fusable
    import pwm_fusable_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [2*NPAIR-1:0]   pwm_out
);

    localparam int NCH = 2 * NPAIR;
    localparam int WW  = 2 * DW;

    logic [NCH-1:0][DW-1:0] per, duty;
    logic [NCH-1:0]         en, pol, ctr;
    logic [NPAIR-1:0]       fuse;

    pwm_fusable_regs #(.NPAIR(NPAIR), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .per_o   (per),
        .duty_o  (duty),
        .en_o    (en),
        .pol_o   (pol),
        .ctr_o   (ctr),
        .fuse_o  (fuse)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int EV = 2 * p;
        localparam int OD = 2 * p + 1;

        logic [WW-1:0] wide_per, wide_duty;
        logic          even_en;

        assign even_en   = en[EV] && !fuse[p];
        assign wide_per  = fuse[p] ? {per[EV],  per[OD]}  : {{DW{1'b0}}, per[OD]};
        assign wide_duty = fuse[p] ? {duty[EV], duty[OD]} : {{DW{1'b0}}, duty[OD]};

        pwm_fusable_engine #(.W(DW)) u_even (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (even_en),
            .pol   (pol[EV]),
            .ctr   (ctr[EV]),
            .per   (per[EV]),
            .duty  (duty[EV]),
            .out   (pwm_out[EV])
        );

        pwm_fusable_engine #(.W(WW)) u_odd (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (en[OD]),
            .pol   (pol[OD]),
            .ctr   (ctr[OD]),
            .per   (wide_per),
            .duty  (wide_duty),
            .out   (pwm_out[OD])
        );

        AST_EVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            fuse[p] |-> !pwm_out[EV]); // R5
    end

endmodule

// File: tb/pwm_fusable_test.sv
module pwm_fusable_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       tick_alt = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [4:0] A_EN  = 5'd16;
    localparam logic [4:0] A_POL = 5'd17;
    localparam logic [4:0] A_CTR = 5'd18;
    localparam logic [4:0] A_FUS = 5'd19;

    always #5 clk = ~clk;

    pwm_fusable uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    initial begin
        tick = 1'b1;
        forever begin
            @(negedge clk);
            tick = tick_alt ? ~tick : 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_chan(input int ch, input int per, input int duty);
        wr(5'(ch), 8'(per));
        wr(5'(8 + ch), 8'(duty));
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) return;
            prev = pwm_out[ch];
        end
    endtask

    task automatic count_run(input int ch, output int n);
        logic lvl;
        lvl = pwm_out[ch];
        n = 1;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) return;
            n++;
        end
    endtask

    function automatic int exp_hi(input int per, input int duty, input bit pol, input bit ctr);
        int h;
        h = pol ? duty : per - duty;
        return ctr ? 2 * h : h;
    endfunction

    task automatic meas_check(input int ch, input int per, input int duty,
                              input bit pol, input bit ctr, input string req);
        int hi, lo, ep;
        ep = ctr ? 2 * per : per;
        repeat (3 * ep + 10) @(negedge clk);
        wait_rise(ch);
        count_run(ch, hi);
        count_run(ch, lo);
        check(hi == exp_hi(per, duty, pol, ctr), req, hi, exp_hi(per, duty, pol, ctr));
        check(hi + lo == ep, req, hi + lo, ep);
    endtask

    task automatic const_check(input int ch, input logic lvl, input int n, input string req);
        int bad;
        bad = 0;
        repeat (20) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check(bad == 0, req, int'(pwm_out[ch]), int'(lvl));
    endtask

    task automatic all_off();
        wr(A_EN, 8'h00);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(pwm_out == 6'd0, "R1 reset outputs", int'(pwm_out), 0);
        wr(A_EN, 8'h3F);
        const_check(0, 1'b0, 30, "R1 unwritten channel 0 low");
        const_check(5, 1'b0, 30, "R1 unwritten channel 5 low");
        all_off();
    endtask

    task automatic t_independent();
        set_chan(0, 10, 3);
        set_chan(1, 4, 1);
        set_chan(2, 6, 2);
        set_chan(3, 8, 2);
        set_chan(4, 9, 7);
        set_chan(5, 5, 4);
        wr(A_POL, 8'b110101);
        wr(A_CTR, 8'b100110);
        wr(A_EN, 8'h3F);
        meas_check(0, 10, 3, 1'b1, 1'b0, "R2 left pol1 ch0");
        meas_check(1, 4, 1, 1'b0, 1'b1, "R3 center pol0 ch1 75pct");
        meas_check(2, 6, 2, 1'b1, 1'b1, "R3 center pol1 ch2");
        meas_check(3, 8, 2, 1'b0, 1'b0, "R2 left pol0 ch3");
        meas_check(4, 9, 7, 1'b1, 1'b0, "R11 independent ch4");
        meas_check(5, 5, 4, 1'b1, 1'b1, "R11 independent ch5");
        all_off();
    endtask

    task automatic t_fuse();
        wr(A_FUS, 8'b010);
        set_chan(2, 8'h01, 8'h00);
        set_chan(3, 8'h2C, 8'h64);
        wr(A_POL, 8'b001000);
        wr(A_CTR, 8'b000000);
        wr(A_EN, 8'b001000);
        meas_check(3, 300, 100, 1'b1, 1'b0, "R5 fused left 300/100");
        const_check(2, 1'b0, 40, "R5 even output idle");
        all_off();
        set_chan(2, 8'h01, 8'h00);
        set_chan(3, 8'h00, 8'h40);
        wr(A_POL, 8'b000000);
        wr(A_CTR, 8'b001000);
        wr(A_EN, 8'b001100);
        meas_check(3, 256, 64, 1'b0, 1'b1, "R5 fused center 256/64");
        const_check(2, 1'b0, 40, "R5 even idle with its enable set");
        all_off();
        wr(A_FUS, 8'b000);
    endtask

    task automatic t_fuse_lock();
        set_chan(4, 10, 5);
        set_chan(5, 7, 3);
        wr(A_POL, 8'b110000);
        wr(A_CTR, 8'b000000);
        wr(A_EN, 8'b010000);
        wr(A_FUS, 8'b100);
        wr(A_EN, 8'b110000);
        meas_check(5, 7, 3, 1'b1, 1'b0, "R6 fuse write ignored ch5");
        meas_check(4, 10, 5, 1'b1, 1'b0, "R6 fuse write ignored ch4");
        all_off();
    endtask

    task automatic t_constant();
        set_chan(0, 0, 0);
        set_chan(1, 6, 6);
        set_chan(2, 6, 9);
        set_chan(3, 6, 0);
        wr(A_POL, 8'b000111);
        wr(A_CTR, 8'b000110);
        wr(A_EN, 8'b001111);
        const_check(0, 1'b1, 40, "R8 period zero gives polarity");
        const_check(1, 1'b1, 40, "R8 duty equal period center");
        const_check(2, 1'b1, 40, "R8 duty above period center");
        const_check(3, 1'b1, 40, "R8 duty zero gives inverse");
        all_off();
    endtask

    task automatic t_shadow();
        int h1, l1, h2, l2;
        set_chan(0, 20, 5);
        wr(A_POL, 8'b000001);
        wr(A_CTR, 8'b000000);
        wr(A_EN, 8'b000001);
        repeat (50) @(negedge clk);
        wait_rise(0);
        fork
            begin
                wr(5'd0, 8'd12);
                wr(5'd8, 8'd4);
            end
        join_none
        count_run(0, h1);
        count_run(0, l1);
        count_run(0, h2);
        count_run(0, l2);
        check(h1 == 5,  "R7 running period keeps old duty", h1, 5);
        check(l1 == 15, "R7 running period keeps old period", l1, 15);
        check(h2 == 4,  "R7 new duty after wrap", h2, 4);
        check(l2 == 8,  "R7 new period after wrap", l2, 8);
    endtask

    task automatic t_disable();
        wr(A_EN, 8'h00);
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R9 disable low", int'(pwm_out[0]), 0);
        const_check(0, 1'b0, 30, "R9 stays low");
    endtask

    task automatic t_tick();
        set_chan(0, 5, 2);
        wr(A_POL, 8'b000001);
        wr(A_CTR, 8'b000000);
        tick_alt = 1'b1;
        wr(A_EN, 8'b000001);
        meas_check(0, 10, 4, 1'b1, 1'b0, "R10 half-rate tick doubles");
        tick_alt = 1'b0;
        all_off();
    endtask

    task automatic t_addr_map();
        // R4: period ch1 at 1, duty ch1 at 9, center bit 1 in register 18
        wr(5'd1, 8'd3);
        wr(5'd9, 8'd2);
        wr(A_POL, 8'b000010);
        wr(A_CTR, 8'b000010);
        wr(A_EN, 8'b000010);
        meas_check(1, 3, 2, 1'b1, 1'b1, "R4 address map ch1 center");
        all_off();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_independent();
        t_fuse();
        t_fuse_lock();
        t_constant();
        t_shadow();
        t_disable();
        t_tick();
        t_addr_map();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule